// File: doc/BRIEF.md
# Photon-counting pixel hit-capture cell

This block is the digital part of one pixel in a photon-counting array. It accepts a discriminated hit pulse from the sensor front end, or a digital test injection, and uses it in three separate ways. It drives a stretched pulse onto the column trigger OR line. It latches a hit bit while an externally driven acceptance window is open. It also holds a serial shift stage that carries the captured pattern to the array edge.

Two configuration bits control how the cell takes part. One disables the cell completely, for a bad pixel. The other removes the cell from the trigger OR only, so a noisy pixel still records hits. When the acceptance window closes, the latched hit moves into the shift stage and the hit flip-flop clears. The cell can then take the next event while the previous pattern is shifted out. All time widths are counted in system clock cycles.

Top module: `spad_hit_cell`

## Requirements
- R1: After reset, `or_o`, `hit_o` and `sr_out_o` are all 0.
- R2: A source is `hit_i | inj_i`, gated by `cfg_en_i`. A rising edge of the source, with the one-shot idle and `cfg_trig_mask_i` low, drives `or_o` high from the next cycle for exactly `cfg_width_i + 1` cycles. A width of 0 gives a 1-cycle pulse.
- R3: A new source rising edge while `or_o` is high neither restarts nor lengthens the pulse.
- R4: With `cfg_trig_mask_i` high, no pulse starts on `or_o`, but hits are still captured into `hit_o`.
- R5: With `cfg_en_i` low, `or_o` is held at 0 and no hit is captured.
- R6: `hit_o` sets when the source and `gate_i` are both high at a clock edge. It stays set until a transfer and never sets while `gate_i` is low.
- R7: A transfer happens at the first clock edge where `gate_i` is low after having been high at the previous edge. At that edge `sr_out_o` takes the old `hit_o` value and `hit_o` clears.
- R8: With `sr_shift_i` high and no transfer, `sr_out_o` takes `sr_in_i` at the clock edge. Shifting never changes `hit_o`.
- R9: When a transfer and `sr_shift_i` fall on the same edge, the transfer wins and `sr_in_i` is discarded.
- R10: `inj_i` has the same effect as `hit_i` on both the trigger pulse and hit capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | 1 | Discriminated sensor hit |
| inj_i | input | 1 | Digital test injection |
| cfg_en_i | input | 1 | Cell enable (0 = bad pixel, silent) |
| cfg_trig_mask_i | input | 1 | Exclude cell from column trigger OR |
| cfg_width_i | input | WIDTH_BITS | One-shot width minus one, in cycles |
| gate_i | input | 1 | Acceptance window, high while open |
| sr_shift_i | input | 1 | Shift-enable of the readout chain |
| sr_in_i | input | 1 | Serial input from the previous cell |
| or_o | output | 1 | Contribution to column hit-OR |
| hit_o | output | 1 | Latched hit bit |
| sr_out_o | output | 1 | Serial output to the next cell |

## Verification
The two functions that can meet in one cycle are the window-close transfer into the shift stage and a shift of the readout chain. A test closes `gate_i` on the same edge that `sr_shift_i` is high, with `sr_in_i` set opposite to the captured hit. Only the captured hit may then show on `sr_out_o`, and `hit_o` must be clear. A second case sends a hit into the window on the cycle before it closes, while the one-shot is still running from an earlier hit. This checks that capture, the trigger pulse and the transfer each keep their own result.

// File: rtl/spad_cell_pkg.sv
package spad_cell_pkg;
  localparam int unsigned WIDTH_BITS = 4;
  typedef logic [WIDTH_BITS-1:0] width_t;
endpackage

// File: rtl/cell_oneshot.sv
module cell_oneshot #(
  parameter int unsigned WIDTH_BITS = spad_cell_pkg::WIDTH_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  active_o
);
  logic [WIDTH_BITS-1:0] cnt_q;
  logic                  busy_q;

  // non-retriggerable: start ignored while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= width_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = busy_q;

  AST_NO_RETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start_i |=> !busy_q); // R2
endmodule

// File: rtl/cell_hit_latch.sv
module cell_hit_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic gate_i,
  output logic hit_o,
  output logic xfer_o
);
  logic gate_q;
  logic hit_q;

  assign xfer_o = gate_q & ~gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (xfer_o)                hit_q <= 1'b0;
      else if (gate_i && src_i)  hit_q <= 1'b1;
    end
  end

  assign hit_o = hit_q;

  AST_XFER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !hit_q); // R7
  AST_CLOSED_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i && !hit_q |=> !hit_q); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q && gate_i |=> hit_q); // R6
endmodule

// File: rtl/cell_shift_stage.sv
module cell_shift_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_val_i,
  input  logic shift_i,
  input  logic ser_i,
  output logic ser_o
);
  logic sr_q;

  // load has priority over shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= 1'b0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= ser_i;
  end

  assign ser_o = sr_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sr_q == $past(load_val_i)); // R9
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !load_i |=> sr_q == $past(ser_i)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i && !load_i |=> $stable(sr_q)); // R8
endmodule

// File: rtl/spad_hit_cell.sv
module spad_hit_cell #(
  parameter int unsigned WIDTH_BITS = spad_cell_pkg::WIDTH_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hit_i,
  input  logic                  inj_i,
  input  logic                  cfg_en_i,
  input  logic                  cfg_trig_mask_i,
  input  logic [WIDTH_BITS-1:0] cfg_width_i,
  input  logic                  gate_i,
  input  logic                  sr_shift_i,
  input  logic                  sr_in_i,
  output logic                  or_o,
  output logic                  hit_o,
  output logic                  sr_out_o
);
  logic src, src_q, rise, os_active, xfer, hit_q;

  assign src  = cfg_en_i & (hit_i | inj_i);
  assign rise = src & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 1'b0;
    else         src_q <= src;
  end

  cell_oneshot #(.WIDTH_BITS(WIDTH_BITS)) i_oneshot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rise & ~cfg_trig_mask_i),
    .width_i  (cfg_width_i),
    .active_o (os_active)
  );

  cell_hit_latch i_hit_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src),
    .gate_i (gate_i),
    .hit_o  (hit_q),
    .xfer_o (xfer)
  );

  cell_shift_stage i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (xfer),
    .load_val_i (hit_q),
    .shift_i    (sr_shift_i),
    .ser_i      (sr_in_i),
    .ser_o      (sr_out_o)
  );

  // disabled cell is silent on the column line
  assign or_o  = os_active & cfg_en_i;
  assign hit_o = hit_q;

  AST_DIS_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i && !hit_o |=> !hit_o); // R5
  AST_MASK_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_trig_mask_i && !os_active |=> !os_active); // R4
  AST_SHIFT_KEEPS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_shift_i && !gate_i && !xfer |=> hit_o == $past(hit_o)); // R8
endmodule

// File: tb/test_spad_hit_cell.sv
module test_spad_hit_cell;
  localparam int unsigned WB = spad_cell_pkg::WIDTH_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit = 0, inj = 0, en = 1, msk = 0, gate = 0, shf = 0, sin = 0;
  logic [WB-1:0] width = '0;
  logic or_w, hit_w, sout_w;

  always #5 clk = ~clk;

  spad_hit_cell i_spad_hit_cell (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .inj_i(inj), .cfg_en_i(en),
    .cfg_trig_mask_i(msk), .cfg_width_i(width), .gate_i(gate),
    .sr_shift_i(shf), .sr_in_i(sin), .or_o(or_w), .hit_o(hit_w), .sr_out_o(sout_w)
  );

  typedef struct { logic o; logic h; logic s; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;

  // reference state, built from the requirements
  logic m_src_q = 0, m_busy = 0, m_gate_q = 0, m_hit = 0, m_sr = 0;
  int   m_left = 0;

  task automatic chk(input logic act, input logic exp, input string what, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: apply inputs, advance one edge, push expected outputs
  task automatic step(input logic h, input logic ij, input logic g,
                      input logic sh, input logic si, input string tag);
    logic src, rise, xfer, old_hit;
    hit = h; inj = ij; gate = g; shf = sh; sin = si;
    src  = en & (h | ij);
    rise = src & ~m_src_q;
    xfer = m_gate_q & ~g;
    old_hit = m_hit;
    if (!m_busy) begin
      if (rise && !msk) begin m_busy = 1; m_left = int'(width); end
    end else if (m_left == 0) m_busy = 0;
    else m_left--;
    if (xfer) m_hit = 0;
    else if (g && src) m_hit = 1;
    if (xfer) m_sr = old_hit;
    else if (sh) m_sr = si;
    m_src_q = src; m_gate_q = g;
    @(posedge clk); #2;
    q.push_back('{o: m_busy & en, h: m_hit, s: m_sr, tag: tag});
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(or_w,   e.o, "or_o",     e.tag);
        chk(hit_w,  e.h, "hit_o",    e.tag);
        chk(sout_w, e.s, "sr_out_o", e.tag);
      end
    end
  end

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(or_w, 1'b0, "or_o", "R1");
    chk(hit_w, 1'b0, "hit_o", "R1");
    chk(sout_w, 1'b0, "sr_out_o", "R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;

    // R2: width 3 -> 4 cycles
    width = 4'd3;
    step(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, "R2");
    // R2: width 0 -> 1 cycle; held level gives one pulse
    width = 4'd0;
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    // R3: second edge during pulse ignored
    width = 4'd5;
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, "R3");
    // R10: injection triggers and captures
    width = 4'd2;
    step(0, 1, 1, 0, 0, "R10");
    step(0, 0, 1, 0, 0, "R10");
    step(0, 0, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R4: masked cell captures but does not trigger
    msk = 1;
    step(0, 0, 1, 0, 0, "R4");
    step(1, 0, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    msk = 0;
    // R8: shift in 1,0,1 without touching hit
    step(0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");
    // R6: hits outside window not captured, inside held
    step(1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 0, 0, "R6");
    step(1, 0, 1, 1, 0, "R6");
    step(0, 0, 1, 1, 1, "R6");
    step(0, 0, 1, 0, 0, "R6");
    // R9: close window while shifting opposite value
    step(0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, "R9");
    // R9: empty window closes while shifting a 1
    step(0, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 1, 1, "R9");
    // R7: hit on last open cycle during running pulse, then close
    width = 4'd6;
    step(1, 0, 1, 0, 0, "R7");
    step(0, 0, 1, 0, 0, "R7");
    step(1, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, "R7");
    // R5: disabled cell silent
    en = 0;
    step(0, 0, 1, 0, 0, "R5");
    step(1, 1, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    en = 1;
    step(0, 0, 0, 0, 0, "R5");

    @(negedge clk); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule